// File: doc/BRIEF.md
# Lockable Address Window Decoder

This block holds the two bounds of a physical address window, one lower and one upper, and tells the rest of the chip whether a 36-bit physical address falls inside that window. Each bound is stored as a 16-bit field in 1 MB units. The lower bound takes all-zero low address bits and the upper bound takes all-one low address bits, so the window always starts on a 1 MB boundary and ends one byte below one. When the lower bound is programmed above the upper bound, the window is switched off and nothing matches.

Software programs the bounds through a dword-wide configuration port with byte enables. Each bound lives in its own 64-bit register, seen as two dwords. Each register carries a sticky lock bit that freezes that register, including the lock bit itself, until reset. A separate external freeze input holds both bound fields, whatever the lock bits say. The hit and enable outputs are combinational from the stored bounds and the address.

Top module: `addr_window_decoder`

## Requirements
- R1: The lower-bound register sits at byte offsets 90h–97h and the upper-bound register at 98h–9Fh. The port takes dword indices, so these are 24h/25h and 26h/27h. In the low dword of each register, bit 0 is the lock bit and bits 31:20 hold field bits 11:0. In the high dword, bits 3:0 hold field bits 15:12.
- R2: All other bits of both registers read as zero, and writes to them have no effect.
- R3: After reset the lower field is FFFFh, the upper field is 0000h and both lock bits are 0, so `win_en` is 0.
- R4: When the window is enabled, `win_hit` is 1 exactly when {lower,00000h} ≤ `phys_addr` ≤ {upper,FFFFFh}, combinationally in the same cycle.
- R5: `win_en` equals (lower field ≤ upper field). When the lower field is greater, `win_hit` is 0 for every address.
- R6: Once a register's lock bit is 1, writes to its field and to its lock bit have no effect until reset.
- R7: While `ext_freeze` is 1, writes to both bound fields have no effect, but the lock bits can still be written.
- R8: A lock bit affects only its own register. The other register stays writable.
- R9: A write updates only the bytes whose enable is set. Within those bytes it updates only the bits not blocked by a lock.
- R10: Read data appears on `cfg_rdata` the cycle after `cfg_rd_en` and holds until the next read. Dword indices outside 24h–27h read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_dw_addr | input | 6 | Dword index into the configuration space |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| ext_freeze | input | 1 | External freeze of both bound fields |
| phys_addr | input | 36 | Address to decode |
| win_en | output | 1 | Window is enabled (lower ≤ upper) |
| win_hit | output | 1 | Address falls inside the enabled window |

## Verification
The assertions assume that `cfg_wr_en` and `cfg_rd_en` are never high in the same cycle, and that every input is stable at the clock edge. The bench meets this by changing inputs only on falling edges and by running each access as its own task. The freeze and no-write properties also assume that nothing but the port strobes changes the registers outside reset. The bench keeps its field sweep within a few megabytes of address, where every bound combination and both edges of each 1 MB step can be visited. It then probes the top of the address space, and fields that cross the dword split, separately.

// File: rtl/awd_pkg.sv
// Package: shared defaults and the internal write-request type for the
// address window decoder. Assumes a 64-bit register image split into
// two 32-bit configuration dwords.
package awd_pkg;

    localparam int unsigned AWD_PA_W   = 36;    // physical address width
    localparam int unsigned AWD_GRAN_W = 20;    // implied low bits (1 MB)
    localparam int unsigned AWD_REG_W  = 64;    // register image width
    localparam int unsigned AWD_DW_W   = 32;    // configuration dword width
    localparam int unsigned AWD_IDX_W  = 6;     // dword index width

    // dword index of the low half of each register
    localparam logic [AWD_IDX_W-1:0] AWD_LO_IDX = 6'h24;   // byte 90h
    localparam logic [AWD_IDX_W-1:0] AWD_HI_IDX = 6'h26;   // byte 98h

    // one write request steered to one register
    typedef struct packed {
        logic                wr_lo;   // write to low dword
        logic                wr_hi;   // write to high dword
        logic [3:0]          be;      // byte enables
        logic [AWD_DW_W-1:0] data;    // write data
    } awd_wr_t;

endpackage

// File: rtl/awd_bound_reg.sv
// Module: one lockable bound register. Holds a bound field at image bits
// PA_W-1:GRAN_W and a sticky lock bit at image bit 0. Every other image
// bit is constant zero. Assumes PA_W <= 64 and GRAN_W >= 1. The lock bit
// freezes the field and itself. ext_freeze freezes the field only.
module awd_bound_reg
    import awd_pkg::*;
#(
    parameter int unsigned PA_W      = AWD_PA_W,
    parameter int unsigned GRAN_W    = AWD_GRAN_W,
    parameter logic [PA_W-GRAN_W-1:0] FIELD_RST = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  awd_wr_t                wr,
    input  logic                   ext_freeze,
    output logic [PA_W-GRAN_W-1:0] field,
    output logic                   lock,
    output logic [AWD_REG_W-1:0]   image
);

    localparam int unsigned FLD_W = PA_W - GRAN_W;
    localparam int unsigned NBYTE = AWD_REG_W / 8;

    logic [FLD_W-1:0]     field_q;
    logic                 lock_q;
    logic [AWD_REG_W-1:0] byte_mask;
    logic [AWD_REG_W-1:0] allow_mask;
    logic [AWD_REG_W-1:0] wmask;
    logic [AWD_REG_W-1:0] wdata64;
    logic [AWD_REG_W-1:0] next_img;

    // build the current image with the reserved bits tied to zero
    always_comb begin
        image               = '0;
        image[PA_W-1:GRAN_W] = field_q;
        image[0]            = lock_q;
    end

    // expand the byte enables over the dword being written
    always_comb begin
        for (int i = 0; i < NBYTE; i++) begin
            if (i < 4)
                byte_mask[8*i +: 8] = {8{wr.wr_lo & wr.be[i % 4]}};
            else
                byte_mask[8*i +: 8] = {8{wr.wr_hi & wr.be[i % 4]}};
        end
    end

    // writable bits: the field unless frozen, the lock bit unless set
    always_comb begin
        allow_mask                = '0;
        allow_mask[PA_W-1:GRAN_W] = {FLD_W{~(lock_q | ext_freeze)}};
        allow_mask[0]             = ~lock_q;
    end

    // merge the write data into the image
    always_comb begin
        wdata64  = {wr.data, wr.data};
        wmask    = byte_mask & allow_mask;
        next_img = (image & ~wmask) | (wdata64 & wmask);
    end

    // register the field and the lock bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= FIELD_RST;
            lock_q  <= 1'b0;
        end else begin
            field_q <= next_img[PA_W-1:GRAN_W];
            lock_q  <= next_img[0];
        end
    end

    assign field = field_q;
    assign lock  = lock_q;

    // R6: a set lock bit stays set until reset
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R6: a set lock bit freezes the field
    a_r6_field_held: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(field_q));

    // R7: the external freeze holds the field
    a_r7_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ext_freeze |=> $stable(field_q));

    // R9: without a write strobe nothing changes
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr.wr_lo || wr.wr_hi) |=> ($stable(field_q) && $stable(lock_q)));

endmodule

// File: rtl/awd_cfg_port.sv
// Module: configuration port. Steers dword writes to the two bound
// registers and returns registered read data one cycle after a read
// strobe. Assumes the lower-bound register sits at two dword indices
// starting at LO_IDX and the upper-bound register at HI_IDX. Other
// indices read zero.
module awd_cfg_port
    import awd_pkg::*;
#(
    parameter logic [AWD_IDX_W-1:0] LO_IDX = AWD_LO_IDX,
    parameter logic [AWD_IDX_W-1:0] HI_IDX = AWD_HI_IDX
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic                 cfg_rd_en,
    input  logic [AWD_IDX_W-1:0] cfg_dw_addr,
    input  logic [3:0]           cfg_be,
    input  logic [AWD_DW_W-1:0]  cfg_wdata,
    input  logic [AWD_REG_W-1:0] lo_image,
    input  logic [AWD_REG_W-1:0] hi_image,
    output awd_wr_t              lo_wr,
    output awd_wr_t              hi_wr,
    output logic [AWD_DW_W-1:0]  cfg_rdata
);

    logic                sel_lo;
    logic                sel_hi;
    logic                upper_dw;
    logic [AWD_DW_W-1:0] rd_mux;
    logic [AWD_DW_W-1:0] rdata_q;

    // decode which register and which dword the index names
    always_comb begin
        sel_lo   = (cfg_dw_addr[AWD_IDX_W-1:1] == LO_IDX[AWD_IDX_W-1:1]);
        sel_hi   = (cfg_dw_addr[AWD_IDX_W-1:1] == HI_IDX[AWD_IDX_W-1:1]);
        upper_dw = cfg_dw_addr[0];
    end

    // form the write request for each register
    always_comb begin
        lo_wr.wr_lo = cfg_wr_en & sel_lo & ~upper_dw;
        lo_wr.wr_hi = cfg_wr_en & sel_lo &  upper_dw;
        lo_wr.be    = cfg_be;
        lo_wr.data  = cfg_wdata;
        hi_wr.wr_lo = cfg_wr_en & sel_hi & ~upper_dw;
        hi_wr.wr_hi = cfg_wr_en & sel_hi &  upper_dw;
        hi_wr.be    = cfg_be;
        hi_wr.data  = cfg_wdata;
    end

    // select the addressed dword, zero for unmapped indices
    always_comb begin
        if (sel_lo)
            rd_mux = upper_dw ? lo_image[63:32] : lo_image[31:0];
        else if (sel_hi)
            rd_mux = upper_dw ? hi_image[63:32] : hi_image[31:0];
        else
            rd_mux = '0;
    end

    // capture read data on a read strobe, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (cfg_rd_en)
            rdata_q <= rd_mux;
    end

    assign cfg_rdata = rdata_q;

    // R10: read data holds between read strobes
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_en |=> $stable(cfg_rdata));

    // R10: an unmapped read returns zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_en && !sel_lo && !sel_hi) |=> (cfg_rdata == '0));

endmodule

// File: rtl/awd_window_match.sv
// Module: combinational window comparator. The lower bound takes all-zero
// low bits and the upper bound takes all-one low bits. The window is
// enabled only when lower <= upper. Assumes GRAN_W < PA_W.
module awd_window_match
    import awd_pkg::*;
#(
    parameter int unsigned PA_W   = AWD_PA_W,
    parameter int unsigned GRAN_W = AWD_GRAN_W
) (
    input  logic [PA_W-GRAN_W-1:0] lo_field,
    input  logic [PA_W-GRAN_W-1:0] hi_field,
    input  logic [PA_W-1:0]        phys_addr,
    output logic                   win_en,
    output logic                   win_hit
);

    logic [PA_W-1:0] lo_addr;
    logic [PA_W-1:0] hi_addr;

    // widen the bounds with their implied low bits
    always_comb begin
        lo_addr = {lo_field, {GRAN_W{1'b0}}};
        hi_addr = {hi_field, {GRAN_W{1'b1}}};
    end

    // compare the address against both inclusive bounds
    always_comb begin
        win_en  = (lo_field <= hi_field);
        win_hit = win_en && (phys_addr >= lo_addr) && (phys_addr <= hi_addr);
    end

endmodule

// File: rtl/addr_window_decoder.sv
// Module: top of the lockable address window decoder. Two bound
// registers, a configuration port and a comparator. Assumes a read and
// a write strobe never coincide.
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int unsigned PA_W   = AWD_PA_W,
    parameter int unsigned GRAN_W = AWD_GRAN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic                 cfg_rd_en,
    input  logic [AWD_IDX_W-1:0] cfg_dw_addr,
    input  logic [3:0]           cfg_be,
    input  logic [AWD_DW_W-1:0]  cfg_wdata,
    output logic [AWD_DW_W-1:0]  cfg_rdata,
    input  logic                 ext_freeze,
    input  logic [PA_W-1:0]      phys_addr,
    output logic                 win_en,
    output logic                 win_hit
);

    localparam int unsigned FLD_W = PA_W - GRAN_W;

    awd_wr_t              lo_wr;
    awd_wr_t              hi_wr;
    logic [FLD_W-1:0]     lo_field;
    logic [FLD_W-1:0]     hi_field;
    logic                 lo_lock;
    logic                 hi_lock;
    logic [AWD_REG_W-1:0] lo_image;
    logic [AWD_REG_W-1:0] hi_image;

    awd_cfg_port u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_rd_en   (cfg_rd_en),
        .cfg_dw_addr (cfg_dw_addr),
        .cfg_be      (cfg_be),
        .cfg_wdata   (cfg_wdata),
        .lo_image    (lo_image),
        .hi_image    (hi_image),
        .lo_wr       (lo_wr),
        .hi_wr       (hi_wr),
        .cfg_rdata   (cfg_rdata)
    );

    awd_bound_reg #(
        .PA_W      (PA_W),
        .GRAN_W    (GRAN_W),
        .FIELD_RST ({FLD_W{1'b1}})
    ) u_lo_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (lo_wr),
        .ext_freeze (ext_freeze),
        .field      (lo_field),
        .lock       (lo_lock),
        .image      (lo_image)
    );

    awd_bound_reg #(
        .PA_W      (PA_W),
        .GRAN_W    (GRAN_W),
        .FIELD_RST ({FLD_W{1'b0}})
    ) u_hi_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (hi_wr),
        .ext_freeze (ext_freeze),
        .field      (hi_field),
        .lock       (hi_lock),
        .image      (hi_image)
    );

    awd_window_match #(
        .PA_W   (PA_W),
        .GRAN_W (GRAN_W)
    ) u_match (
        .lo_field  (lo_field),
        .hi_field  (hi_field),
        .phys_addr (phys_addr),
        .win_en    (win_en),
        .win_hit   (win_hit)
    );

    // R3: the window is disabled in the first cycle after reset
    a_r3_reset_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !win_en);

    // R5: an inverted pair of bounds never produces a hit
    a_r5_inverted_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_field > hi_field) |-> !win_hit);

    // R4: a hit lies at or above the lower bound's 1 MB block
    a_r4_hit_above_lo: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (phys_addr[PA_W-1:GRAN_W] >= lo_field));

    // R8: the upper-bound lock does not hold the lower-bound lock bit
    a_r8_lock_separate: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_lock && !lo_lock && lo_wr.wr_lo && lo_wr.be[0] && lo_wr.data[0])
        |=> lo_lock);

endmodule

// File: tb/addr_window_decoder_bench.sv
module addr_window_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_rd_en = 1'b0;
    logic [5:0]  cfg_dw_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ext_freeze = 1'b0;
    logic [35:0] phys_addr = '0;
    logic        win_en;
    logic        win_hit;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    addr_window_decoder u_addr_window_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
        .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ext_freeze(ext_freeze), .phys_addr(phys_addr),
        .win_en(win_en), .win_hit(win_hit)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_dw_addr = idx; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_be = '0;
    endtask

    task automatic rd(input logic [5:0] idx, output logic [31:0] d);
        @(negedge clk);
        cfg_rd_en = 1'b1; cfg_dw_addr = idx;
        @(negedge clk);
        cfg_rd_en = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] idx, input logic [31:0] exp);
        logic [31:0] d;
        rd(idx, d);
        chk(req, d, exp);
    endtask

    task automatic set_bounds(input logic [15:0] lo, input logic [15:0] hi);
        wr(6'h24, 4'hF, {lo[11:0], 20'h0});
        wr(6'h25, 4'hF, {28'h0, lo[15:12]});
        wr(6'h26, 4'hF, {hi[11:0], 20'h0});
        wr(6'h27, 4'hF, {28'h0, hi[15:12]});
    endtask

    task automatic probe(input string req, input logic [35:0] a, input logic exp);
        @(negedge clk);
        phys_addr = a;
        #1;
        chk(req, win_hit, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        do_reset();
        // R3 / R1 reset images
        rd_chk("R3", 6'h24, 32'hFFF0_0000);
        rd_chk("R3", 6'h25, 32'h0000_000F);
        rd_chk("R3", 6'h26, 32'h0);
        rd_chk("R3", 6'h27, 32'h0);
        @(negedge clk); #1;
        chk("R3", win_en, 1'b0);
        probe("R5", 36'hFFFF0_0000, 1'b0);
        // R10 unmapped reads and hold
        rd_chk("R10", 6'h22, 32'h0);
        rd_chk("R10", 6'h28, 32'h0);
        rd_chk("R10", 6'h25, 32'hF);
        repeat (3) @(negedge clk);
        chk("R10", cfg_rdata, 32'hF);
        // R2 reserved bits ignore writes, read zero
        wr(6'h25, 4'hF, 32'hFFFF_FFF5);
        rd_chk("R2", 6'h25, 32'h5);
        wr(6'h24, 4'hF, 32'h000F_FFFE);
        rd_chk("R2", 6'h24, 32'h0);
        // R4 / R5 sweep over small bounds
        for (int b = 0; b < 6; b++) begin
            for (int l = 0; l < 6; l++) begin
                set_bounds(16'(b), 16'(l));
                @(negedge clk); #1;
                chk("R5", win_en, (b <= l));
                for (int f = 0; f < 7; f++) begin
                    probe("R4", 36'(f) << 20, (b <= l) && (f >= b) && (f <= l));
                    probe("R4", (36'(f) << 20) | 36'hFFFFF, (b <= l) && (f >= b) && (f <= l));
                end
            end
        end
        // R4 fields across the dword split and top of space
        set_bounds(16'h1234, 16'h1235);
        probe("R4", 36'h1233F_FFFF, 1'b0);
        probe("R4", 36'h12340_0000, 1'b1);
        probe("R4", 36'h1235F_FFFF, 1'b1);
        probe("R4", 36'h12360_0000, 1'b0);
        set_bounds(16'hFFFF, 16'hFFFF);
        probe("R4", 36'hFFFFF_FFFF, 1'b1);
        probe("R4", 36'hFFFEF_FFFF, 1'b0);
        // R9 partial byte enables on the upper register
        set_bounds(16'hFFFF, 16'h1235);
        wr(6'h26, 4'b0100, 32'hABC0_0001);
        rd_chk("R9", 6'h26, 32'h23C0_0000);
        wr(6'h26, 4'b1000, 32'h9870_0001);
        rd_chk("R9", 6'h26, 32'h98C0_0000);
        rd_chk("R9", 6'h27, 32'h1);
        // R7 freeze holds fields, lock bit still written (R9 partial block)
        ext_freeze = 1'b1;
        wr(6'h24, 4'hF, 32'h7770_0001);
        wr(6'h27, 4'hF, 32'h0000_0003);
        rd_chk("R7", 6'h24, 32'hFFF0_0001);
        rd_chk("R7", 6'h27, 32'h1);
        ext_freeze = 1'b0;
        // R6 lower register self-locked
        wr(6'h24, 4'hF, 32'h0000_0000);
        rd_chk("R6", 6'h24, 32'hFFF0_0001);
        wr(6'h25, 4'hF, 32'h0);
        rd_chk("R6", 6'h25, 32'hF);
        // R8 upper register still writable and lockable
        wr(6'h27, 4'hF, 32'h2);
        rd_chk("R8", 6'h27, 32'h2);
        wr(6'h26, 4'hF, 32'h0000_0001);
        rd_chk("R8", 6'h26, 32'h0000_0001);
        wr(6'h26, 4'hF, 32'h5550_0000);
        rd_chk("R6", 6'h26, 32'h0000_0001);
        // R6 reset clears the lock
        do_reset();
        rd_chk("R6", 6'h24, 32'hFFF0_0000);
        wr(6'h24, 4'hF, 32'h0010_0000);
        rd_chk("R6", 6'h24, 32'h0010_0000);
        rd(6'h26, d);
        chk("R3", d, 32'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule